// File: doc/BRIEF.md
# Sixteen-bit Compare Timer with Software-Forced Matches

This block is a free-running up-counter with two output-compare channels, A and B. While the count-enable input is high, the counter advances by one on each clock. On every such timer tick it is checked against each channel's compare value. When a channel matches, that channel's waveform pin is updated according to its 2-bit action field, and its interrupt flag is raised. An optional clear-on-match setting turns channel A's compare value into the top of the count.

Software can load the counter directly. The tick that follows such a load performs no compare on either channel, so a freshly loaded value that equals a compare value does not fire at once. Software can also pulse a force strobe per channel to apply that channel's pin action immediately. A forced action never raises a flag and never clears the counter. It is honoured only while the non-PWM indicator is high.

Top module: `fct_timer16`

## Requirements
- R1: While reset is asserted and right after it, the counter reads 0, and both waveform pins and both flags are 0.
- R2: Each clock with `cnt_en` high and no load adds one to the counter. The counter holds while `cnt_en` is low. A tick at 0xFFFF gives 0 when no clear-on-match applies.
- R3: A load (`cnt_wr_en` high) puts `cnt_wr_data` into the counter on the next clock. A load takes precedence over a tick in the same cycle.
- R4: A real match happens when a tick finds the counter equal to a channel's compare value. On a real match, the channel's pin takes its new value on the next clock according to its action field: 00 keeps the pin, 01 inverts it, 10 drives it to 0 and 11 drives it to 1.
- R5: A real match sets the channel's flag. The flag stays set until a one on that channel's flag-clear input. When a match and a clear arrive together, the flag ends up set.
- R6: With `ctc_en` high, a real match on channel A makes that tick load 0 instead of incrementing. A match on channel B never alters the count.
- R7: With `non_pwm` high, a force strobe applies the channel's action field (the same encoding as in R4) to its pin on the next clock, whatever the count and the enable.
- R8: A forced action never sets the channel's flag.
- R9: A forced action never clears or otherwise alters the counter, including when `ctc_en` is high.
- R10: With `non_pwm` low, force strobes have no effect on the pins.
- R11: After a load, the first tick that follows performs no compare on either channel, however many idle cycles come in between. Later ticks compare normally. The load cycle itself performs no compare.
- R12: When a force and a real match hit the same channel in the same cycle, the action is applied once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Timer tick: count this cycle |
| cnt_wr_en | input | 1 | Load the counter |
| cnt_wr_data | input | 16 | Value to load |
| cmp_a | input | 16 | Compare value, channel A |
| cmp_b | input | 16 | Compare value, channel B |
| mode_a | input | 2 | Pin action field, channel A |
| mode_b | input | 2 | Pin action field, channel B |
| non_pwm | input | 1 | High when the timer runs in a non-PWM mode |
| ctc_en | input | 1 | Clear counter on channel A match |
| force_a | input | 1 | Force strobe, channel A |
| force_b | input | 1 | Force strobe, channel B |
| flag_clr_a | input | 1 | Write-one-to-clear for flag A |
| flag_clr_b | input | 1 | Write-one-to-clear for flag B |
| cnt | output | 16 | Current counter value |
| wave_a | output | 1 | Waveform pin, channel A |
| wave_b | output | 1 | Waveform pin, channel B |
| flag_a | output | 1 | Match flag, channel A |
| flag_b | output | 1 | Match flag, channel B |

## Verification
The pin action is tried with every action code from both pin starting levels. Each combination is reached once through a real match and once through a force, so the only thing that tells the two paths apart is the flag. Counter loads are combined with compare values equal to the loaded value and one above it. This separates blocking the next tick from blocking the next cycle, and shows that only one tick is blocked. Clear-on-match runs are paired with forced actions and with a channel B match, which shows that only a real channel A match ends the count. A force that coincides with a toggle match separates a single application from a double one.

// File: rtl/fct_timer_pkg.sv
package fct_timer_pkg;

   typedef enum logic [1:0] {
      PIN_KEEP   = 2'b00,
      PIN_INVERT = 2'b01,
      PIN_LOW    = 2'b10,
      PIN_HIGH   = 2'b11
   } pin_action_e;

   function automatic logic apply_action(input logic [1:0] act, input logic pin);
      case (pin_action_e'(act))
         PIN_KEEP:   apply_action = pin;
         PIN_INVERT: apply_action = ~pin;
         PIN_LOW:    apply_action = 1'b0;
         default:    apply_action = 1'b1;
      endcase
   endfunction

endpackage

// File: rtl/fct_count_core.sv
module fct_count_core #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             ld_en,
   input  logic [CNT_W-1:0] ld_val,
   input  logic             zero_on_tick,
   output logic [CNT_W-1:0] value,
   output logic             cmp_open
);

   localparam logic [CNT_W-1:0] STEP = {{(CNT_W-1){1'b0}}, 1'b1};

   logic             guard_q;
   logic [CNT_W-1:0] value_q;

   // a load arms the guard; the first tick afterwards consumes it
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         guard_q <= 1'b0;
      else if (ld_en)
         guard_q <= 1'b1;
      else if (tick)
         guard_q <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         value_q <= '0;
      else if (ld_en)
         value_q <= ld_val;
      else if (tick) begin
         if (zero_on_tick)
            value_q <= '0;
         else
            value_q <= value_q + STEP;
      end
   end

   assign value    = value_q;
   assign cmp_open = tick & ~ld_en & ~guard_q;

endmodule

// File: rtl/fct_cmp_unit.sv
module fct_cmp_unit
   import fct_timer_pkg::*;
#(
   parameter int   CNT_W    = 16,
   parameter logic PIN_INIT = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] value,
   input  logic [CNT_W-1:0] ref_val,
   input  logic [1:0]       action,
   input  logic             cmp_open,
   input  logic             force_req,
   input  logic             force_ok,
   input  logic             ack,
   output logic             hit,
   output logic             pin,
   output logic             irq
);

   logic pin_q;
   logic irq_q;
   logic fire;

   assign hit  = cmp_open & (value == ref_val);
   // a force and a real hit in one cycle collapse into one application
   assign fire = hit | (force_req & force_ok);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pin_q <= PIN_INIT;
      else if (fire)
         pin_q <= apply_action(action, pin_q);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         irq_q <= 1'b0;
      else if (hit)
         irq_q <= 1'b1;
      else if (ack)
         irq_q <= 1'b0;
   end

   assign pin = pin_q;
   assign irq = irq_q;

endmodule

// File: rtl/fct_timer16.sv
module fct_timer16 #(
   parameter int   CNT_W    = 16,
   parameter logic PIN_INIT = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cnt_en,
   input  logic             cnt_wr_en,
   input  logic [CNT_W-1:0] cnt_wr_data,
   input  logic [CNT_W-1:0] cmp_a,
   input  logic [CNT_W-1:0] cmp_b,
   input  logic [1:0]       mode_a,
   input  logic [1:0]       mode_b,
   input  logic             non_pwm,
   input  logic             ctc_en,
   input  logic             force_a,
   input  logic             force_b,
   input  logic             flag_clr_a,
   input  logic             flag_clr_b,
   output logic [CNT_W-1:0] cnt,
   output logic             wave_a,
   output logic             wave_b,
   output logic             flag_a,
   output logic             flag_b
);

   localparam int N_CH   = 2;
   localparam int TOP_CH = 0;

   if (CNT_W < 2 || CNT_W > 32) begin : g_bad_width
      $error("fct_timer16: CNT_W must lie in 2..32");
   end

   logic [CNT_W-1:0] ch_ref   [N_CH];
   logic [1:0]       ch_act   [N_CH];
   logic [N_CH-1:0]  ch_force;
   logic [N_CH-1:0]  ch_ack;
   logic [N_CH-1:0]  ch_hit;
   logic [N_CH-1:0]  ch_pin;
   logic [N_CH-1:0]  ch_irq;
   logic             cmp_open;
   logic [CNT_W-1:0] value;

   assign ch_ref[0] = cmp_a;
   assign ch_ref[1] = cmp_b;
   assign ch_act[0] = mode_a;
   assign ch_act[1] = mode_b;
   assign ch_force  = {force_b, force_a};
   assign ch_ack    = {flag_clr_b, flag_clr_a};

   fct_count_core #(.CNT_W(CNT_W)) u_core (
      .clk          (clk),
      .rst_n        (rst_n),
      .tick         (cnt_en),
      .ld_en        (cnt_wr_en),
      .ld_val       (cnt_wr_data),
      .zero_on_tick (ctc_en & ch_hit[TOP_CH]),
      .value        (value),
      .cmp_open     (cmp_open)
   );

   for (genvar c = 0; c < N_CH; c++) begin : g_ch
      fct_cmp_unit #(.CNT_W(CNT_W), .PIN_INIT(PIN_INIT)) u_unit (
         .clk       (clk),
         .rst_n     (rst_n),
         .value     (value),
         .ref_val   (ch_ref[c]),
         .action    (ch_act[c]),
         .cmp_open  (cmp_open),
         .force_req (ch_force[c]),
         .force_ok  (non_pwm),
         .ack       (ch_ack[c]),
         .hit       (ch_hit[c]),
         .pin       (ch_pin[c]),
         .irq       (ch_irq[c])
      );
   end

   assign cnt    = value;
   assign wave_a = ch_pin[0];
   assign wave_b = ch_pin[1];
   assign flag_a = ch_irq[0];
   assign flag_b = ch_irq[1];

endmodule

// File: rtl/fct_timer16_chk.sv
module fct_timer16_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cnt_en,
   input logic             cnt_wr_en,
   input logic [CNT_W-1:0] cnt_wr_data,
   input logic [1:0]       mode_a,
   input logic             non_pwm,
   input logic             ctc_en,
   input logic             force_a,
   input logic [CNT_W-1:0] cnt,
   input logic             wave_a,
   input logic             flag_a,
   input logic             hit_a,
   input logic             hit_b
);

   localparam logic [CNT_W-1:0] TOPV = '1;
   localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

   logic pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pend_q <= 1'b0;
      else if (cnt_wr_en)
         pend_q <= 1'b1;
      else if (cnt_en)
         pend_q <= 1'b0;
   end

   p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!cnt_en && !cnt_wr_en) |=> $stable(cnt));

   p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_en && !cnt_wr_en && cnt == TOPV && !(ctc_en && hit_a)) |=> cnt == '0);

   p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_wr_en |=> cnt == $past(cnt_wr_data));

   p_set_action_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_a && mode_a == 2'b11) |=> wave_a);

   p_flag_on_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
      hit_a |=> flag_a);

   p_force_no_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (force_a && !hit_a && !flag_a) |=> !flag_a);

   p_force_keeps_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (force_a && ctc_en && cnt_en && !cnt_wr_en && !hit_a) |=> cnt == $past(cnt) + ONE);

   p_force_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!non_pwm && !hit_a) |=> $stable(wave_a));

   p_blocked_after_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && cnt_en) |-> (!hit_a && !hit_b));

endmodule

bind fct_timer16 fct_timer16_chk #(.CNT_W(CNT_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cnt_en      (cnt_en),
   .cnt_wr_en   (cnt_wr_en),
   .cnt_wr_data (cnt_wr_data),
   .mode_a      (mode_a),
   .non_pwm     (non_pwm),
   .ctc_en      (ctc_en),
   .force_a     (force_a),
   .cnt         (cnt),
   .wave_a      (wave_a),
   .flag_a      (flag_a),
   .hit_a       (ch_hit[0]),
   .hit_b       (ch_hit[1])
);

// File: tb/tb_fct_timer16.sv
module tb_fct_timer16;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        cnt_en, cnt_wr_en, non_pwm, ctc_en;
   logic [15:0] cnt_wr_data, cmp_a, cmp_b;
   logic [1:0]  mode_a, mode_b;
   logic        force_a, force_b, flag_clr_a, flag_clr_b;
   logic [15:0] cnt;
   logic        wave_a, wave_b, flag_a, flag_b;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 0;

   always #2 clk = ~clk;

   fct_timer16 dut (
      .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .cnt_wr_en(cnt_wr_en),
      .cnt_wr_data(cnt_wr_data), .cmp_a(cmp_a), .cmp_b(cmp_b),
      .mode_a(mode_a), .mode_b(mode_b), .non_pwm(non_pwm), .ctc_en(ctc_en),
      .force_a(force_a), .force_b(force_b), .flag_clr_a(flag_clr_a),
      .flag_clr_b(flag_clr_b), .cnt(cnt), .wave_a(wave_a), .wave_b(wave_b),
      .flag_a(flag_a), .flag_b(flag_b)
   );

   // {action[1:0], pin_start, via_force, exp_pin, exp_flag}
   localparam logic [5:0] VEC [16] = '{
      6'b00_0_0_0_1, 6'b00_1_0_1_1, 6'b01_0_0_1_1, 6'b01_1_0_0_1,
      6'b10_0_0_0_1, 6'b10_1_0_0_1, 6'b11_0_0_1_1, 6'b11_1_0_1_1,
      6'b00_0_1_0_0, 6'b00_1_1_1_0, 6'b01_0_1_1_0, 6'b01_1_1_0_0,
      6'b10_0_1_0_0, 6'b10_1_1_0_0, 6'b11_0_1_1_0, 6'b11_1_1_1_0
   };

   task automatic cyc(input int n = 1);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %0h, expected %0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      cnt_en = 0; cnt_wr_en = 0; cnt_wr_data = '0; non_pwm = 1; ctc_en = 0;
      cmp_a = 16'hFFFF; cmp_b = 16'hFFFF; mode_a = 2'b00; mode_b = 2'b00;
      force_a = 0; force_b = 0; flag_clr_a = 0; flag_clr_b = 0;
      cyc(2);
      rst_n = 1'b1;
      cyc();
   endtask

   task automatic load(input logic [15:0] v);
      cnt_wr_en = 1; cnt_wr_data = v;
      cyc();
      cnt_wr_en = 0;
   endtask

   initial begin
      @(negedge clk);
      do_reset();
      check("R1 cnt", cnt, 0);
      check("R1 pins", {wave_a, wave_b}, 0);
      check("R1 flags", {flag_a, flag_b}, 0);

      // action table, both channels, via match and via force
      for (int i = 0; i < 16; i++) begin
         do_reset();
         if (VEC[i][3]) begin
            mode_a = 2'b11; mode_b = 2'b11; force_a = 1; force_b = 1;
            cyc();
            force_a = 0; force_b = 0;
         end
         mode_a = VEC[i][5:4]; mode_b = VEC[i][5:4];
         if (VEC[i][2]) begin
            force_a = 1; force_b = 1;
            cyc();
            force_a = 0; force_b = 0;
         end else begin
            cmp_a = 16'd2; cmp_b = 16'd2; cnt_en = 1;
            cyc(3);
            cnt_en = 0;
         end
         check(VEC[i][2] ? "R7 pin A" : "R4 pin A", wave_a, VEC[i][1]);
         check(VEC[i][2] ? "R7 pin B" : "R4 pin B", wave_b, VEC[i][1]);
         check(VEC[i][2] ? "R8 flags" : "R5 flags", {flag_a, flag_b}, {2{VEC[i][0]}});
      end

      // R2 count and hold
      do_reset();
      cnt_en = 1; cyc(5); cnt_en = 0;
      check("R2 count", cnt, 5);
      cyc(3);
      check("R2 hold", cnt, 5);

      // R3 load over tick, then R2 wrap
      cnt_en = 1; load(16'hFFFE);
      check("R3 load priority", cnt, 16'hFFFE);
      cyc(2); cnt_en = 0;
      check("R2 wrap", cnt, 0);

      // R11 blocking of the next tick after a load
      do_reset();
      mode_a = 2'b01; mode_b = 2'b01; cmp_a = 16'h0101; cmp_b = 16'h0101;
      load(16'h0101);
      cyc(3);
      cnt_en = 1; cyc(); cnt_en = 0;
      check("R11 cnt", cnt, 16'h0102);
      check("R11 no flag", {flag_a, flag_b}, 0);
      check("R11 no pin", wave_a, 0);
      load(16'h0100);
      cnt_en = 1; cyc(2); cnt_en = 0;
      check("R11 later tick flags", {flag_a, flag_b}, 2'b11);
      check("R11 later tick pin", wave_a, 1);

      // R5 clear and set-wins
      flag_clr_a = 1; cyc(); flag_clr_a = 0;
      check("R5 clear A", flag_a, 0);
      check("R5 B kept", flag_b, 1);
      load(16'h00FF);
      cnt_en = 1; cyc(2);
      flag_clr_a = 1; cyc();
      cnt_en = 0; flag_clr_a = 0;
      check("R5 set wins", flag_a, 1);

      // R6 clear on match
      do_reset();
      ctc_en = 1; cmp_a = 16'd3; cmp_b = 16'd1;
      cnt_en = 1; cyc(2);
      check("R6 B match keeps count", cnt, 2);
      check("R6 B flag", flag_b, 1);
      cyc(2); cnt_en = 0;
      check("R6 A match clears", cnt, 0);
      check("R6 A flag", flag_a, 1);

      // R9 / R8 force under clear-on-match
      do_reset();
      ctc_en = 1; mode_a = 2'b01; cmp_a = 16'd5;
      cnt_en = 1; cyc(5); cnt_en = 0;
      force_a = 1; cyc(); force_a = 0;
      check("R9 count kept", cnt, 5);
      check("R7 forced toggle", wave_a, 1);
      check("R8 no flag", flag_a, 0);

      // R10 force ignored outside non-PWM
      do_reset();
      non_pwm = 0; mode_a = 2'b11; mode_b = 2'b11;
      force_a = 1; force_b = 1; cyc(); force_a = 0; force_b = 0;
      check("R10 pins", {wave_a, wave_b}, 0);

      // R12 force and match together
      do_reset();
      mode_a = 2'b01; cmp_a = 16'd2;
      cnt_en = 1; cyc(2);
      force_a = 1; cyc();
      cnt_en = 0; force_a = 0;
      check("R12 single toggle", wave_a, 1);
      check("R12 flag", flag_a, 1);

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: got timeout, expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
         $finish;
      end
   end

endmodule